// File: doc/BRIEF.md
# TSB Pointer Generator

This block forms the address of a translation storage buffer entry after a TLB miss. System software writes a tag-access value, a single legacy TSB descriptor, four per-context TSB descriptors and two context page-size descriptors through a register write port. A read request then returns a 64-bit pointer for one of two page-size slots.

The pointer is built from two parts. The upper part comes from the selected descriptor's base. The lower part comes from the faulting virtual address, shifted right according to the page size. A mode input picks between two ways of choosing the descriptor and the page size:

- **Legacy mode:** one descriptor is used, with a fixed 8K or 64K page size.
- **Hypervisor mode:** the context number and the slot choose one of four descriptors and one of two page-size codes.

Top module: `tsb_ptr_gen`

## Requirements
- R1: After reset every stored value is zero, `rd_valid` is 0 and `rd_ptr` is 0. A read issued with nothing written returns 0.
- R2: A write stores into the register named by `wr_sel` and takes effect at the next clock. The select codes are: 0 tag-access, 1 legacy descriptor, 2..5 descriptors 0..3, 6 context config for context zero, 7 context config for nonzero contexts.
- R3: In hypervisor mode the context number is tag-access bits 12:0. Descriptor index {context nonzero, slot} selects one of the four descriptors. Context zero uses context config code 6 and a nonzero context uses code 7.
- R4: In hypervisor mode the page-size code is config bits 2:0 for slot 0 and config bits 10:8 for slot 1.
- R5: In legacy mode the page-size code equals the slot (0 gives 8K, 1 gives 64K) and the legacy descriptor is used.
- R6: The pointer is (D & M) | (V & ~M), where:
  - D is the descriptor;
  - M is ~0x1FFF shifted left by descriptor bits 3:0;
  - V is tag-access with bits 12:0 cleared, shifted right by 3*code+9.
- R7: When descriptor bit 12 (split) is set, M is shifted left one further place and bit 13+size of V is replaced by the slot value.
- R8: `rd_valid` is high exactly one cycle after a cycle with `rd_req` high, and low otherwise.
- R9: `rd_ptr` holds its value in cycles without a request. Mode and slot are taken from the request cycle only.
- R10: When a write and a read fall in the same cycle, the read uses the values stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 64 | Write data |
| rd_req | input | 1 | Pointer read request |
| rd_slot | input | 1 | Page-size slot (0 or 1) |
| hv_mode | input | 1 | 1 selects hypervisor mode, 0 selects legacy mode |
| rd_valid | output | 1 | Pointer valid, one cycle after the request |
| rd_ptr | output | 64 | Computed TSB entry pointer |

## Verification
A write is visible to a read issued in the next cycle. A pointer is due on the outputs one clock after its request.

The driver changes inputs on falling edges and pushes one expected pointer per request into a queue. The monitor also works on falling edges: each time it sees `rd_valid`, it pops one entry, which is exactly one edge after the push. In cycles without `rd_valid`, the monitor compares `rd_ptr` against the last delivered pointer. At the end of the run, the queue must be empty.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    localparam int ADDR_W     = 64;
    localparam int CTX_W      = 13;
    localparam int BASE_LSB   = 13;
    localparam int SPLIT_BIT  = 12;
    localparam int SZ_W       = 4;
    localparam int CODE_W     = 3;
    localparam int CODE0_LSB  = 0;
    localparam int CODE1_LSB  = 8;
    localparam int NUM_TSB    = 4;
    localparam int NUM_CTX    = 2;
    localparam int SHIFT_BASE = 9;
    localparam int SHIFT_STEP = 3;
    localparam int SEL_W      = 3;
    localparam int SH_W       = 6;
    localparam int VA_W       = ADDR_W - CTX_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_TAG    = 3'd0,
        SEL_LEGACY = 3'd1,
        SEL_TSB0   = 3'd2,
        SEL_TSB1   = 3'd3,
        SEL_TSB2   = 3'd4,
        SEL_TSB3   = 3'd5,
        SEL_CFG0   = 3'd6,
        SEL_CFG1   = 3'd7
    } wsel_e;

    typedef struct packed {
        logic [ADDR_W-1:BASE_LSB] base;
        logic                     split;
        logic [SZ_W-1:0]          size;
    } tsb_desc_t;

    typedef struct packed {
        logic [CODE_W-1:0] code1;
        logic [CODE_W-1:0] code0;
    } ctx_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0]              tag;
        tsb_desc_t                      legacy;
        tsb_desc_t [NUM_TSB-1:0]        tsb;
        ctx_cfg_t  [NUM_CTX-1:0]        cfg;
    } regs_t;

    function automatic tsb_desc_t pack_desc(input logic [ADDR_W-1:0] d);
        tsb_desc_t r;
        r.base  = d[ADDR_W-1:BASE_LSB];
        r.split = d[SPLIT_BIT];
        r.size  = d[SZ_W-1:0];
        return r;
    endfunction

    function automatic ctx_cfg_t pack_cfg(input logic [ADDR_W-1:0] d);
        ctx_cfg_t r;
        r.code0 = d[CODE0_LSB +: CODE_W];
        r.code1 = d[CODE1_LSB +: CODE_W];
        return r;
    endfunction
endpackage

// File: rtl/tsb_regfile.sv
module tsb_regfile
    import tsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output regs_t             regs
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                SEL_TAG:    regs_d.tag     = wr_data;
                SEL_LEGACY: regs_d.legacy  = pack_desc(wr_data);
                SEL_TSB0:   regs_d.tsb[0]  = pack_desc(wr_data);
                SEL_TSB1:   regs_d.tsb[1]  = pack_desc(wr_data);
                SEL_TSB2:   regs_d.tsb[2]  = pack_desc(wr_data);
                SEL_TSB3:   regs_d.tsb[3]  = pack_desc(wr_data);
                SEL_CFG0:   regs_d.cfg[0]  = pack_cfg(wr_data);
                SEL_CFG1:   regs_d.cfg[1]  = pack_cfg(wr_data);
                default:    regs_d         = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    AST_WRITE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_TAG) |=> (regs_q.tag == $past(wr_data))); // R2
    AST_WRITE_LEGACY_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_LEGACY) |=>
        (regs_q.legacy.base == $past(wr_data[ADDR_W-1:BASE_LSB]))); // R2
endmodule

// File: rtl/tsb_select.sv
module tsb_select
    import tsb_pkg::*;
(
    input  regs_t               regs,
    input  logic                hv_mode,
    input  logic                slot,
    output tsb_desc_t           desc,
    output logic [CODE_W-1:0]   code
);
    logic     ctx_nz;
    ctx_cfg_t cfg_sel;
    logic [$clog2(NUM_TSB)-1:0] tsb_idx;

    always_comb begin
        ctx_nz  = |regs.tag[CTX_W-1:0];
        cfg_sel = regs.cfg[ctx_nz];
        tsb_idx = {ctx_nz, slot};
        if (hv_mode) begin
            desc = regs.tsb[tsb_idx];
            code = slot ? cfg_sel.code1 : cfg_sel.code0;
        end else begin
            desc = regs.legacy;
            code = CODE_W'(slot);
        end
    end
endmodule

// File: rtl/tsb_ptr_calc.sv
module tsb_ptr_calc
    import tsb_pkg::*;
(
    input  logic [VA_W-1:0]   va_hi,
    input  tsb_desc_t         desc,
    input  logic [CODE_W-1:0] code,
    input  logic              slot,
    output logic [ADDR_W-1:0] ptr
);
    logic [SH_W-1:0]   shamt;
    logic [SH_W-1:0]   bitpos;
    logic [ADDR_W-1:0] va_sh;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_full;

    always_comb begin
        shamt     = SH_W'(SHIFT_BASE) + SH_W'(code) * SH_W'(SHIFT_STEP);
        bitpos    = SH_W'(BASE_LSB) + SH_W'(desc.size);
        va_sh     = {va_hi, {CTX_W{1'b0}}} >> shamt;
        mask      = ({ADDR_W{1'b1}} << BASE_LSB) << desc.size;
        base_full = {desc.base, {BASE_LSB{1'b0}}};
        if (desc.split) begin
            va_sh[bitpos] = slot;
            mask          = mask << 1;
        end
        ptr = (base_full & mask) | (va_sh & ~mask);
    end
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
    import tsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              rd_slot,
    input  logic              hv_mode,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_ptr
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] ptr;
    } out_t;

    regs_t             regs;
    tsb_desc_t         sel_desc;
    logic [CODE_W-1:0] sel_code;
    logic [ADDR_W-1:0] calc_ptr;
    out_t              out_d, out_q;

    tsb_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .regs(regs)
    );

    tsb_select u_sel (
        .regs(regs), .hv_mode(hv_mode), .slot(rd_slot),
        .desc(sel_desc), .code(sel_code)
    );

    tsb_ptr_calc u_calc (
        .va_hi(regs.tag[ADDR_W-1:CTX_W]), .desc(sel_desc), .code(sel_code),
        .slot(rd_slot), .ptr(calc_ptr)
    );

    always_comb begin
        out_d.valid = rd_req;
        out_d.ptr   = rd_req ? calc_ptr : out_q.ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_valid = out_q.valid;
    assign rd_ptr   = out_q.ptr;

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid); // R8
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_ptr)); // R9
    AST_SPLIT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel_desc.split) |=>
        (rd_ptr[SH_W'(BASE_LSB) + SH_W'($past(sel_desc.size))] == $past(rd_slot))); // R7
endmodule

// File: tb/tb_tsb_ptr_gen.sv
module tb_tsb_ptr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [63:0] ptr;
        string       req;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_sel = 0;
    logic [63:0] wr_data = 0;
    logic        rd_req = 0;
    logic        rd_slot = 0;
    logic        hv_mode = 0;
    logic        rd_valid;
    logic [63:0] rd_ptr;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t q[$];
    logic [63:0] last_ptr = 0;

    logic [63:0] m_tag = 0, m_leg = 0;
    logic [63:0] m_tsb [4];
    logic [63:0] m_cfg [2];

    tsb_ptr_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_req(rd_req), .rd_slot(rd_slot), .hv_mode(hv_mode),
        .rd_valid(rd_valid), .rd_ptr(rd_ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] model(bit slot, bit hv);
        logic        nz;
        logic [63:0] cfg, r, va, msk;
        int          code;
        nz  = |m_tag[12:0];
        cfg = nz ? m_cfg[1] : m_cfg[0];
        if (hv) begin
            code = slot ? int'(cfg[10:8]) : int'(cfg[2:0]);
            r    = m_tsb[{nz, slot}];
        end else begin
            code = int'(slot);
            r    = m_leg;
        end
        va  = {m_tag[63:13], 13'b0} >> (code * 3 + 9);
        msk = 64'hFFFF_FFFF_FFFF_E000 << r[3:0];
        if (r[12]) begin
            va[13 + int'(r[3:0])] = slot;
            msk = msk << 1;
        end
        return (r & msk) | (va & ~msk);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one driven cycle: optional write and optional read
    task automatic step(bit we, logic [2:0] sel, logic [63:0] data,
                        bit rd, bit slot, bit hv, string req);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = data;
        rd_req = rd; rd_slot = slot; hv_mode = hv;
        if (rd) begin
            e.ptr = model(slot, hv);
            e.req = req;
            q.push_back(e);
        end
        if (we) begin
            case (sel)
                3'd0: m_tag = data;
                3'd1: m_leg = data;
                3'd2, 3'd3, 3'd4, 3'd5: m_tsb[int'(sel) - 2] = data;
                default: m_cfg[int'(sel) - 6] = data;
            endcase
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [63:0] data);
        step(1, sel, data, 0, 0, 0, "R2");
    endtask

    task automatic rd(bit slot, bit hv, string req);
        step(0, 0, 0, 1, slot, hv, req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "");
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_valid) begin
                if (q.size() == 0) begin
                    check(0, "R8 unexpected valid", {63'b0, rd_valid}, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rd_ptr === e.ptr, e.req, rd_ptr, e.ptr);
                    last_ptr = e.ptr;
                end
            end else begin
                check(rd_ptr === last_ptr, "R9 hold", rd_ptr, last_ptr);
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_tsb[i] = 0;
        for (int i = 0; i < 2; i++) m_cfg[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_valid === 1'b0, "R1 valid", {63'b0, rd_valid}, 64'd0);
        check(rd_ptr === 64'd0, "R1 ptr", rd_ptr, 64'd0);
        rst_n = 1;
        rd(0, 0, "R1 read");
        rd(1, 1, "R1 read");

        // R2 then R5: legacy descriptor, 8K and 64K slots
        wr(3'd0, 64'h0000_1234_5678_A000);
        wr(3'd1, 64'h0000_0080_0000_0002);
        rd(0, 0, "R5 slot0");
        rd(1, 0, "R5 slot1");
        idle(1);

        // hypervisor descriptors and configs
        wr(3'd2, 64'h0000_0100_0000_0001);
        wr(3'd3, 64'h0000_0200_0000_0003);
        wr(3'd4, 64'h0000_0300_0000_0000);
        wr(3'd5, 64'h0000_0400_0000_0005);
        wr(3'd6, 64'h0000_0000_0000_0501);
        wr(3'd7, 64'h0000_0000_0000_0302);
        // context zero
        rd(0, 1, "R3 ctx0 slot0");
        rd(1, 1, "R4 ctx0 slot1");
        // nonzero context
        wr(3'd0, 64'hFEDC_BA98_7654_3001);
        rd(0, 1, "R3 ctx1 slot0");
        rd(1, 1, "R4 ctx1 slot1");
        rd(1, 0, "R5 legacy with ctx");

        // R6 largest page code and largest size
        wr(3'd7, 64'h0000_0000_0000_0707);
        wr(3'd5, 64'hFFFF_0000_0000_000F);
        rd(1, 1, "R6 code7 size15");
        rd(0, 1, "R6 code7 slot0");

        // R7 split descriptors
        wr(3'd4, 64'h0000_0500_0000_1002);
        wr(3'd5, 64'hFFFF_FFFF_FFFF_F00F);
        rd(0, 1, "R7 split slot0");
        rd(1, 1, "R7 split slot1 size15");
        wr(3'd1, 64'h1111_2222_3333_1004);
        rd(0, 0, "R7 legacy split slot0");
        rd(1, 0, "R7 legacy split slot1");

        // R10 write and read in one cycle
        step(1, 3'd1, 64'h0000_0000_0000_0000, 1, 0, 0, "R10 old value");
        rd(0, 0, "R2 new value");
        step(1, 3'd0, 64'h0000_0000_0000_0000, 1, 1, 1, "R10 old tag");
        rd(1, 1, "R3 ctx back to zero");

        // R8/R9 back to back mode flips, then idle hold
        wr(3'd0, 64'hAAAA_5555_CCCC_3333);
        rd(0, 1, "R9 hv");
        rd(0, 0, "R9 legacy");
        rd(1, 1, "R9 hv slot1");
        step(0, 0, 0, 0, 0, 1, "");
        step(0, 0, 0, 0, 1, 0, "");
        idle(3);

        @(negedge clk);
        done = 1;
        check(q.size() == 0, "R8 pending", 64'(q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule